// File: doc/BRIEF.md
# Dithered Five-Channel PWM Generator

This block drives five output pins. Each pin can carry a pulse-width-modulated waveform or a plain output level taken from a general-purpose input vector. One prescaler is shared by all channels. It divides the input clock by 2, 4, 8 or 16, and one prescaled tick is one step of a 32-step PWM period. Each channel has an 8-bit setting. The coarse part sets how many ticks of each period are high. The fine part lengthens the high time by one tick in a chosen number of the eight periods that make up a repeating frame, so the average duty has 256 levels.

Software writes the settings through a small write port made of an enable, a 3-bit address and an 8-bit data bus. A new channel setting is held in a pending register and becomes active only when the next frame begins. A running frame therefore never mixes two settings. Writing the divider selection restarts all counters, and a new frame begins at once.

Top module: `dither_pwm`

## Requirements
- R1: After reset every enable bit, the divider selection and every channel setting are zero. Each pin shows its `gpo` bit, and an enabled channel that has never been written stays low.
- R2: Address 6 takes the divider code from data bits [1:0]. Code 0 gives one tick per 2 clocks, code 1 per 4, code 2 per 8 and code 3 per 16.
- R3: A period is 32 ticks and a period counter runs from 0 to 31. A channel is high while the counter is below its coarse value, which is bits [7:3] of its setting. A coarse value of 0 with a fine value of 0 is constant low.
- R4: The fine value N is bits [2:0] of the setting. For frame index f, take r as f with its three bits reversed. The period with index f is one tick longer when r < N, so N of the eight periods are extended.
- R5: A 3-bit frame index advances after tick 31 of each period and wraps from 7 to 0.
- R6: Addresses 0 to 4 write the setting of channels 0 to 4. A new setting is used from the first cycle of the next frame. A write in the same cycle as a frame boundary is used by the frame that starts there.
- R7: Address 5 writes enable bits from data bits [4:0], with bit i for channel i. When bit i is 1, pin i carries the PWM waveform. When it is 0, pin i follows `gpo[i]` in the same cycle.
- R8: A write to address 6 clears the prescaler, the period counter and the frame index. A new frame begins there, which loads the pending settings.
- R9: A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| gpo | input | 5 | General-purpose levels for pins whose enable bit is 0 |
| pin | output | 5 | Output pins |

## Verification
Two events can fall in the same cycle: a channel write and the frame boundary that loads pending settings. The bench uses its reference model to find the cycle whose rising edge ends tick 31 of period 7. It places the write so that it is sampled on exactly that edge. The check is that the new value shapes the very first tick of the new frame, not the frame after it. A divider write also starts a frame. It is issued in the middle of a frame, and the pin timing that follows is compared with the model cycle by cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int DUTY_W = 5;
    localparam int FINE_W = 3;
    localparam int DATA_W = DUTY_W + FINE_W;
    localparam int SEL_W  = 2;
    localparam int PRE_W  = 1 << SEL_W;

    typedef logic [DUTY_W-1:0] cnt_t;
    typedef logic [FINE_W-1:0] frame_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        cnt_t             cnt;
        frame_t           frame;
    } tbase_t;

    typedef struct packed {
        data_t pend;
        data_t act;
    } chan_t;

    function automatic frame_t bit_rev(frame_t v);
        frame_t r;
        for (int k = 0; k < FINE_W; k++) begin
            r[k] = v[FINE_W-1-k];
        end
        return r;
    endfunction

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
    import dpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output cnt_t             cnt,
    output frame_t           frame,
    output logic             frame_start
);

    tbase_t s_d, s_q;
    logic [PRE_W:0]   div_full;
    logic [PRE_W-1:0] limit;
    logic             tick;
    logic             cnt_max;
    logic             frame_max;

    always_comb begin
        div_full  = (PRE_W+1)'(2) << sel;
        limit     = div_full[PRE_W-1:0] - PRE_W'(1);
        tick      = (s_q.pre == limit);
        cnt_max   = &s_q.cnt;
        frame_max = &s_q.frame;
        s_d       = s_q;
        if (restart) begin
            s_d = '0;
        end else if (tick) begin
            s_d.pre = '0;
            s_d.cnt = s_q.cnt + cnt_t'(1);
            if (cnt_max) begin
                s_d.frame = s_q.frame + frame_t'(1);
            end
        end else begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
        frame_start = restart || (tick && cnt_max && frame_max);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt   = s_q.cnt;
    assign frame = s_q.frame;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && s_q.pre != limit) |=> $stable(s_q.cnt)); // R2

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(&s_q.cnt)) |=> $stable(s_q.frame)); // R5

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.cnt == '0 && s_q.frame == '0 && s_q.pre == '0)); // R8

endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
    import dpwm_pkg::*;
#(
    parameter int CHANNELS = 5,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CHANNELS-1:0] en_wdata,
    input  logic [SEL_W-1:0]    sel_wdata,
    output logic [CHANNELS-1:0] en,
    output logic [SEL_W-1:0]    sel,
    output logic                restart,
    output logic [CHANNELS-1:0] ch_wr
);

    localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(CHANNELS);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(CHANNELS + 1);

    typedef struct packed {
        logic [CHANNELS-1:0] en;
        logic [SEL_W-1:0]    sel;
    } regs_t;

    regs_t s_d, s_q;
    logic  en_hit;

    for (genvar i = 0; i < CHANNELS; i++) begin : g_dec
        assign ch_wr[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    always_comb begin
        en_hit  = wr_en && (wr_addr == EN_ADDR);
        restart = wr_en && (wr_addr == SEL_ADDR);
        s_d     = s_q;
        if (en_hit) begin
            s_d.en = en_wdata;
        end
        if (restart) begin
            s_d.sel = sel_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en  = s_q.en;
    assign sel = s_q.sel;

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (sel == $past(sel_wdata))); // R8

    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == EN_ADDR) |=> $stable(en)); // R7

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_wr, restart})); // R9

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr,
    input  data_t  wdata,
    input  logic   load,
    input  cnt_t   cnt,
    input  frame_t frame,
    output logic   pwm
);

    chan_t              s_d, s_q;
    logic [DUTY_W-1:0]  duty;
    logic [FINE_W-1:0]  fine;
    logic               extend;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            s_d.pend = wdata;
        end
        if (load) begin
            s_d.act = s_d.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        duty   = s_q.act[DATA_W-1:FINE_W];
        fine   = s_q.act[FINE_W-1:0];
        extend = (bit_rev(frame) < fine);
        pwm    = (cnt < duty) || ((cnt == duty) && extend);
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(s_q.act)); // R6

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act == '0) |-> !pwm); // R3

    AST_WR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (s_q.pend == $past(wdata))); // R6

endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
    import dpwm_pkg::*;
#(
    parameter int CHANNELS = 5,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [CHANNELS-1:0] gpo,
    output logic [CHANNELS-1:0] pin
);

    logic [CHANNELS-1:0] en;
    logic [SEL_W-1:0]    sel;
    logic                restart;
    logic [CHANNELS-1:0] ch_wr;
    logic [CHANNELS-1:0] pwm;
    cnt_t                cnt;
    frame_t              frame;
    logic                frame_start;

    dpwm_regs #(
        .CHANNELS (CHANNELS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .en_wdata  (wr_data[CHANNELS-1:0]),
        .sel_wdata (wr_data[SEL_W-1:0]),
        .en        (en),
        .sel       (sel),
        .restart   (restart),
        .ch_wr     (ch_wr)
    );

    dpwm_timebase u_tbase (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .restart     (restart),
        .cnt         (cnt),
        .frame       (frame),
        .frame_start (frame_start)
    );

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        dpwm_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (ch_wr[i]),
            .wdata (wr_data),
            .load  (frame_start),
            .cnt   (cnt),
            .frame (frame),
            .pwm   (pwm[i])
        );
        assign pin[i] = en[i] ? pwm[i] : gpo[i];
    end

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (pin == gpo)); // R1

endmodule

// File: tb/dither_pwm_bench.sv
`timescale 1ns/1ps
module dither_pwm_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] gpo = 5'b10101;
    logic [4:0] pin;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    string phase = "R1";

    int m_pre = 0, m_cnt = 0, m_frame = 0, m_sel = 0, m_en = 0;
    int m_pend [5] = '{0, 0, 0, 0, 0};
    int m_act  [5] = '{0, 0, 0, 0, 0};

    always #4 clk = ~clk;

    dither_pwm u_dither_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .gpo     (gpo),
        .pin     (pin)
    );

    function automatic int rev3(int f);
        return ((f & 1) << 2) | (f & 2) | ((f >> 2) & 1);
    endfunction

    function automatic int m_limit();
        return (2 << m_sel) - 1;
    endfunction

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_frame = 0; m_sel = 0; m_en = 0;
            for (int i = 0; i < 5; i++) begin
                m_pend[i] = 0; m_act[i] = 0;
            end
        end else begin
            bit rs, tk, wrap;
            rs   = wr_en && (wr_addr == 3'd6);
            tk   = (m_pre == m_limit());
            wrap = tk && (m_cnt == 31) && (m_frame == 7);
            if (wr_en && wr_addr < 3'd5) m_pend[wr_addr] = int'(wr_data);
            if (rs) begin
                m_pre = 0; m_cnt = 0; m_frame = 0;
                m_sel = int'(wr_data) & 3;
                for (int i = 0; i < 5; i++) m_act[i] = m_pend[i];
            end else if (tk) begin
                m_pre = 0;
                if (m_cnt == 31) m_frame = (m_frame + 1) % 8;
                m_cnt = (m_cnt + 1) % 32;
                if (wrap) for (int i = 0; i < 5; i++) m_act[i] = m_pend[i];
            end else begin
                m_pre = m_pre + 1;
            end
            if (wr_en && wr_addr == 3'd5) m_en = int'(wr_data) & 31;
        end
    end

    function automatic bit m_pin(int i);
        int d, n;
        d = m_act[i] >> 3;
        n = m_act[i] & 7;
        if (((m_en >> i) & 1) == 0) return gpo[i];
        return (m_cnt < d) || ((m_cnt == d) && (rev3(m_frame) < n));
    endfunction

    always @(negedge clk) begin
        #2;
        if (rst_n && running) begin
            for (int i = 0; i < 5; i++) begin
                checks++;
                if (pin[i] !== m_pin(i)) begin
                    errors++;
                    $display("FAIL %s pin[%0d] at %0t: actual %b expected %b",
                             phase, i, $time, pin[i], m_pin(i));
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(int ch, int cycles, output int n);
        n = 0;
        repeat (cycles) begin
            @(negedge clk); #3;
            n += int'(pin[ch]);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #3;
        check("R1 pins follow gpo in reset", int'(pin), 5'b10101);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk); #3;
        check("R1 pins follow gpo after reset", int'(pin), 5'b10101);

        phase = "R1";
        wr(5, 8'h1F);
        repeat (40) @(negedge clk);
        #3;
        check("R1 unwritten channels low", int'(pin), 0);

        phase = "R4";
        wr(0, 8'h80);
        wr(1, 8'h47);
        wr(2, 8'hFB);
        wr(3, 8'h0D);
        wr(4, 8'h02);
        repeat (1100) @(negedge clk);
        count_high(0, 512, n); check("R3 coarse 16 high cycles per frame", n, 256);
        count_high(4, 512, n); check("R4 fine 2 only narrow pulses", n, 4);
        count_high(3, 512, n); check("R4 coarse 1 fine 5", n, 26);
        phase = "R5";
        count_high(2, 512, n); check("R5 coarse 31 fine 3 over frame", n, 502);

        phase = "R6";
        wr(1, 8'h00);
        count_high(1, 512, n);
        while (!(m_pre == m_limit() && m_cnt == 31 && m_frame == 7)) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h47;
        @(negedge clk);
        wr_en = 1'b0;
        #3;
        check("R6 boundary write used in first tick", int'(pin[1]), 1);
        wr(1, 8'h00);
        #3;
        check("R6 mid-frame write deferred", int'(pin[1]), 1);
        wr(1, 8'h47);
        repeat (600) @(negedge clk);

        phase = "R8";
        repeat (77) @(negedge clk);
        wr(6, 8'h03);
        repeat (143) @(negedge clk);
        #3;
        check("R8 restart, div16, high through extended tick", int'(pin[1]), 1);
        @(negedge clk); #3;
        check("R8 restart, div16, low after extended tick", int'(pin[1]), 0);
        phase = "R2";
        repeat (4300) @(negedge clk);
        wr(6, 8'h01);
        repeat (1500) @(negedge clk);
        wr(6, 8'h02);
        repeat (2500) @(negedge clk);
        wr(6, 8'h00);
        repeat (40) @(negedge clk);

        phase = "R9";
        wr(7, 8'hFF);
        count_high(0, 512, n); check("R9 address 7 leaves channel 0", n, 256);
        #3;
        check("R9 address 7 leaves enables", m_en, 31);

        phase = "R7";
        wr(5, 8'h0A);
        gpo = 5'b10001;
        @(negedge clk); #3;
        check("R7 disabled pins follow gpo", int'(pin & 5'b10101), 5'b10001);
        gpo = 5'b00100;
        #1;
        check("R7 gpo change seen same cycle", int'(pin & 5'b10101), 5'b00100);
        repeat (600) @(negedge clk);

        running = 1'b0;
        finish_run();
    end

endmodule